// File: doc/BRIEF.md
# Cascadable 4-bit Arithmetic Slice

This block is a combinational arithmetic slice. It operates on a 4-bit accumulator value and a 4-bit data-storage value. A 3-bit operation code picks one of eight functions: add, increment, three subtractions with different operand roles, decrement, and rotation left or right through the carry lines. Each result comes with a carry out and raw zero, negative and overflow indicators. The block holds no state, and every output follows its inputs.

Two copies are chained to build an 8-bit unit. The copy with `hi_pos` low is the low-word slice. For arithmetic it ignores `cin`, and it never reports overflow. Its `cout` feeds the `cin` of the copy with `hi_pos` high, the high-word slice. That slice folds the incoming carry into its sum and reports the overflow of the whole word.

The two positions handle subtraction differently. The low slice two's-complements the subtracted operand. The high slice one's-complements it and takes the incoming carry in place of the +1. A carry out of 1 from a subtraction means no borrow occurred.

Rotation always uses `cin` and `cout` as the bit entering and the bit leaving the slice. With the carry lines wired round between the two slices, the pair rotates as one 8-bit word. A high `en_n` forces every output to zero.

Top module: `alu_slice`

## Requirements
- R1: With op 3'b000 (add), {cout,res} equals acc + dsto + k, where k is cin when hi_pos=1 and 0 when hi_pos=0.
- R2: With op 3'b001 (count up), the low position gives {cout,res} = acc + 1 and the high position gives acc + cin. dsto has no effect in either position.
- R3: With op 3'b100 (subtract), res equals acc + ~dsto + c modulo 16, and cout is the carry out of that sum. Here c is 1 in the low position and cin in the high position.
- R4: With op 3'b010 (reverse subtract), res and cout come from dsto + ~acc + c, with c as in R3.
- R5: With op 3'b011 (negate), res and cout come from 0 + ~acc + c, with c as in R3. dsto has no effect.
- R6: With op 3'b101 (count down), the low position computes acc + 4'b1110 + 1 and the high position computes acc + 4'b1111 + cin. cout is the carry out of that sum, and dsto has no effect.
- R7: With op 3'b110 (rotate left), res = {acc[2:0], cin} and cout = acc[3], in both positions.
- R8: With op 3'b111 (rotate right), res = {cin, acc[3:1]} and cout = acc[0], in both positions.
- R9: While enabled, zero is 1 exactly when res is 0, and neg equals res[3], for every operation.
- R10: In the high position with an arithmetic operation, ovf is 1 when the signed 4-bit sum X + Y + c does not fit in -8..7, where X, Y and c are the operands of R1 to R6. For a rotation, ovf is acc[3] XOR res[3].
- R11: In the low position, ovf is 0 for every operation.
- R12: While en_n is 1, res, cout, zero, neg and ovf are all 0, whatever the other inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Active-low enable; high forces all outputs to zero |
| hi_pos | input | 1 | Slice position: 0 low word, 1 high word |
| op | input | 3 | Operation code |
| acc | input | 4 | Accumulator operand |
| dsto | input | 4 | Data-storage operand |
| cin | input | 1 | Carry in, or bit rotated in |
| res | output | 4 | Result |
| cout | output | 1 | Carry out, or bit rotated out |
| zero | output | 1 | Result is zero |
| neg | output | 1 | Result bit 3 |
| ovf | output | 1 | Signed overflow, high position only |

## Verification
The slice holds no state, so a wrong operand select or carry choice shows at the ports as soon as the inputs settle. The error appears only for the operation code, position and operand values that exercise it. A position-dependent fault, such as taking cin in the low slice or using the wrong constant in count down, changes only half of the input space. For this reason the sweep covers every combination of operation, position, both operands, carry and enable. Each output is compared against arithmetic computed independently in the bench.

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int WIDTH = 4
) (
  input  logic             en_n,
  input  logic             hi_pos,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] dsto,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             zero,
  output logic             neg,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = {{MSB{1'b0}}, 1'b1};

  typedef enum logic [2:0] {
    OP_ADD = 3'b000, OP_CU  = 3'b001, OP_SM  = 3'b010, OP_SMZ = 3'b011,
    OP_SUB = 3'b100, OP_CD  = 3'b101, OP_ROL = 3'b110, OP_ROR = 3'b111
  } op_e;

  logic [WIDTH-1:0] opx, opy, cnst, low_sum, r_res;
  logic [1:0]       top_sum;
  logic             k, c_into_msb, is_rot, r_cout, r_ovf;

  assign cnst = hi_pos ? '0 : ONE;

  always_comb begin
    opx = acc;
    opy = dsto;
    k   = hi_pos & cin;
    case (op_e'(op))
      OP_ADD: begin opx = acc;  opy = dsto;  k = hi_pos & cin;  end
      OP_CU:  begin opx = acc;  opy = cnst;  k = hi_pos & cin;  end
      OP_SM:  begin opx = dsto; opy = ~acc;  k = hi_pos ? cin : 1'b1; end
      OP_SMZ: begin opx = '0;   opy = ~acc;  k = hi_pos ? cin : 1'b1; end
      OP_SUB: begin opx = acc;  opy = ~dsto; k = hi_pos ? cin : 1'b1; end
      OP_CD:  begin opx = acc;  opy = ~cnst; k = hi_pos ? cin : 1'b1; end
      default: begin opx = acc; opy = dsto;  k = 1'b0; end
    endcase
  end

  assign {c_into_msb, low_sum[MSB-1:0]} = {1'b0, opx[MSB-1:0]} + {1'b0, opy[MSB-1:0]}
                                        + {{MSB{1'b0}}, k};
  assign top_sum = {1'b0, opx[MSB]} + {1'b0, opy[MSB]} + {1'b0, c_into_msb};
  assign low_sum[MSB] = top_sum[0];

  assign is_rot = (op == OP_ROL) || (op == OP_ROR);

  always_comb begin
    if (op == OP_ROL) begin
      r_res  = {acc[MSB-1:0], cin};
      r_cout = acc[MSB];
    end else if (op == OP_ROR) begin
      r_res  = {cin, acc[MSB:1]};
      r_cout = acc[0];
    end else begin
      r_res  = low_sum;
      r_cout = top_sum[1];
    end
  end

  assign r_ovf = is_rot ? (acc[MSB] ^ r_res[MSB]) : (c_into_msb ^ top_sum[1]);

  assign res  = en_n ? '0 : r_res;
  assign cout = ~en_n & r_cout;
  assign zero = ~en_n & (r_res == '0);
  assign neg  = ~en_n & r_res[MSB];
  assign ovf  = ~en_n & hi_pos & r_ovf;
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
  parameter int WIDTH = 4
) (
  input logic             en_n,
  input logic             hi_pos,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] acc,
  input logic [WIDTH-1:0] dsto,
  input logic             cin,
  input logic [WIDTH-1:0] res,
  input logic             cout,
  input logic             zero,
  input logic             neg,
  input logic             ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    AST_DISABLED_QUIET: assert (!en_n || ({res, cout, zero, neg, ovf} == '0)); // R12
    AST_ZERO_FLAG: assert (en_n || (zero == (res == '0))); // R9
    AST_NEG_FLAG: assert (en_n || (neg == res[MSB])); // R9
    AST_NO_LOW_OVERFLOW: assert (en_n || hi_pos || !ovf); // R11
    AST_ADD_SUM: assert (en_n || op != 3'b000 ||
      ({cout, res} == ({1'b0, acc} + {1'b0, dsto} + {{WIDTH{1'b0}}, hi_pos & cin}))); // R1
    AST_ROTATE_LEFT: assert (en_n || op != 3'b110 ||
      (res == {acc[MSB-1:0], cin} && cout == acc[MSB])); // R7
    AST_ROTATE_RIGHT: assert (en_n || op != 3'b111 ||
      (res == {cin, acc[MSB:1]} && cout == acc[0])); // R8
  end
endmodule

bind alu_slice alu_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .en_n(en_n), .hi_pos(hi_pos), .op(op), .acc(acc), .dsto(dsto), .cin(cin),
  .res(res), .cout(cout), .zero(zero), .neg(neg), .ovf(ovf)
);

// File: tb/tb_alu_slice.sv
module tb_alu_slice;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       en_n, hi_pos, cin;
  logic [2:0] op;
  logic [3:0] acc, dsto, res;
  logic       cout, zero, neg, ovf;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alu_slice #(.WIDTH(4)) dut (
    .en_n(en_n), .hi_pos(hi_pos), .op(op), .acc(acc), .dsto(dsto), .cin(cin),
    .res(res), .cout(cout), .zero(zero), .neg(neg), .ovf(ovf)
  );

  function automatic int sx(input int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  // returns {res[3:0], cout, zero, neg, ovf}
  function automatic logic [7:0] model(input int o, input int a, input int b,
                                       input int c, input int h, input int e);
    int x, y, k, s, r, co, ov;
    if (e != 0) return 8'h00;
    x = a; y = b; k = h ? c : 0; ov = 0;
    case (o)
      0: begin x = a; y = b; k = h ? c : 0; end                 // R1
      1: begin x = a; y = h ? 0 : 1; k = h ? c : 0; end         // R2
      2: begin x = b; y = 15 - a; k = h ? c : 1; end            // R4
      3: begin x = 0; y = 15 - a; k = h ? c : 1; end            // R5
      4: begin x = a; y = 15 - b; k = h ? c : 1; end            // R3
      5: begin x = a; y = h ? 15 : 14; k = h ? c : 1; end       // R6
      default: ;
    endcase
    if (o == 6) begin                                           // R7
      r = ((a * 2) % 16) + c; co = a / 8;
      ov = (a / 8) ^ (r / 8);
    end else if (o == 7) begin                                  // R8
      r = (a / 2) + c * 8; co = a % 2;
      ov = (a / 8) ^ (r / 8);
    end else begin
      s = x + y + k; r = s % 16; co = s / 16;
      s = sx(x) + sx(y) + k;
      ov = (s > 7 || s < -8) ? 1 : 0;                           // R10
    end
    if (h == 0) ov = 0;                                         // R11
    return {r[3:0], co[0], (r == 0), r[3], ov[0]};              // R9
  endfunction

  task automatic check(input int o, input int a, input int b, input int c,
                       input int h, input int e);
    logic [7:0] exp_v, got;
    string tag;
    exp_v = model(o, a, b, c, h, e);
    got = {res, cout, zero, neg, ovf};
    checks++;
    if (got !== exp_v) begin
      errors++;
      case (o)
        0: tag = "R1"; 1: tag = "R2"; 2: tag = "R4"; 3: tag = "R5";
        4: tag = "R3"; 5: tag = "R6"; 6: tag = "R7"; default: tag = "R8";
      endcase
      if (e != 0) tag = "R12";
      $display("FAIL %s/R9/R10/R11 op=%0d acc=%0d dsto=%0d cin=%0d hi=%0d en_n=%0d actual=%b expected=%b",
               tag, o, a, b, c, h, e, got, exp_v);
    end
  endtask

  initial begin
    en_n = 1'b1; hi_pos = 1'b0; cin = 1'b0; op = 3'd0; acc = 4'd0; dsto = 4'd0;
    fork
      begin
        @(negedge clk);
        check(0, 0, 0, 0, 0, 1);  // R12 disabled output state
        for (int e = 0; e < 2; e++)
          for (int h = 0; h < 2; h++)
            for (int o = 0; o < 8; o++)
              for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                  for (int c = 0; c < 2; c++) begin
                    @(posedge clk);
                    en_n = e[0]; hi_pos = h[0]; op = o[2:0];
                    acc = a[3:0]; dsto = b[3:0]; cin = c[0];
                    @(negedge clk);
                    check(o, a, b, c, h, e);
                  end
        done = 1'b1;
      end
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule